// File: doc/BRIEF.md
# Power Partition Gating Controller

This block controls the power state of up to 32 independently switched power partitions through a small register bus. Software does not write the on/off state of a partition directly. It issues a one-shot toggle command that names a partition. The block then inverts that partition's power-enable output and waits for the partition's power-good input to follow before it reports the new state.

A status register gives one bit per partition. Each bit changes only once the partition's power-good input has confirmed the request. A write-one-to-release register removes the isolation clamp of a powered partition. In that register, the bits of two designated partitions (index 3 and index 4 by default) trade places.

The usual power-up sequence is:
- Toggle the partition on.
- Poll the status register until the partition reads as on.
- Release its clamp.

Powering a partition off puts its clamp back on at once.

Top module: `pgate_ctrl`

## Requirements
- R1: After reset, every power enable is 0, every status bit is 0, every isolation clamp is 1, and a read of the status register returns 0.
- R2: A write to offset 0x30 with bit 8 set and bits [4:0] holding index i (i < NPART) inverts pwr_en[i] on the clock edge that takes the write. No other enable changes.
- R3: A write to offset 0x30 with bit 8 clear has no effect on any power enable.
- R4: A status bit takes the new state on the first clock edge at which the partition's pwr_good equals its pwr_en. Until then, the bit keeps its old value.
- R5: A toggle that names a partition whose previous toggle has not yet completed is ignored.
- R6: Reading offset 0x38 returns the status, with bit n set when partition n is on. Every other offset reads 0.
- R7: Writing ones to offset 0x34 releases (drives to 0) the clamp of each selected partition that is currently powered on. Zero bits, and bits that select an unpowered partition, have no effect.
- R8: In offset 0x34, bit SWAP_A releases partition SWAP_B and bit SWAP_B releases partition SWAP_A. Every other bit n releases partition n.
- R9: A toggle that turns a partition off sets its clamp to 1 on the same edge on which its enable falls.
- R10: A toggle whose index is NPART or larger has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| pwr_en | output | NPART | Power-enable request per partition |
| pwr_good | input | NPART | Power-good acknowledge per partition |
| iso_clamp | output | NPART | Isolation clamp per partition, 1 = clamped |

## Verification
Enables and clamps are registered. They change on the edge that takes a write, so the bench drives each write at a falling edge and checks these outputs at the next falling edge. A status bit changes on the first edge that sees a matching power-good. The bench raises or lowers power-good at a falling edge and reads the status register one full cycle later. Because the read path is combinational, each read is taken a fraction of a nanosecond after the address is set. Each partition of an eight-partition build is swept on and then partly off, and every clamp bit is released in turn, with the expected masks worked out arithmetically.

// File: rtl/pgate_pkg.sv
// Package: register offsets, field positions and the clamp-bit mapping
// shared by the decoder, the slices and the checker.
package pgate_pkg;
    localparam int OFF_TOGGLE  = 'h30;
    localparam int OFF_RELEASE = 'h34;
    localparam int OFF_STATUS  = 'h38;
    localparam int START_BIT   = 8;
    localparam int IDX_FIELD_W = 5;

    // Which release-register bit serves partition p (a symmetric swap).
    function automatic int rel_bit(input int p, input int sa, input int sb);
        if (p == sa)      return sb;
        else if (p == sb) return sa;
        else              return p;
    endfunction
endpackage

// File: rtl/pgate_regdec.sv
// Write decoder: turns a bus write into one-hot toggle selects and a
// per-partition release vector. Assumes one write per bus_we cycle and
// NPART <= DATA_W, NPART <= 2**IDX_FIELD_W.
module pgate_regdec
    import pgate_pkg::*;
#(
    parameter int NPART  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SWAP_A = 3,
    parameter int SWAP_B = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [NPART-1:0]  tog_sel,
    output logic [NPART-1:0]  rel_req
);
    logic                   tog_hit;
    logic                   rel_hit;
    logic [IDX_FIELD_W-1:0] tog_idx;

    // Address match for the two writable registers.
    always_comb begin
        tog_hit = bus_we && (bus_addr == ADDR_W'(OFF_TOGGLE)) && bus_wdata[START_BIT];
        rel_hit = bus_we && (bus_addr == ADDR_W'(OFF_RELEASE));
        tog_idx = bus_wdata[IDX_FIELD_W-1:0];
    end

    for (genvar p = 0; p < NPART; p++) begin : g_sel
        localparam int RB = rel_bit(p, SWAP_A, SWAP_B);
        // One-hot toggle select and swapped release bit for partition p.
        always_comb begin
            tog_sel[p] = tog_hit && (tog_idx == IDX_FIELD_W'(p));
            rel_req[p] = rel_hit && bus_wdata[RB];
        end
    end
endmodule

// File: rtl/pgate_slice.sv
// One partition: enable, pending flag, confirmed status and clamp.
// Assumes tog and rel never arrive in the same cycle (distinct offsets).
module pgate_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic tog,
    input  logic rel,
    input  logic pg,
    output logic en,
    output logic stat,
    output logic clamp
);
    logic busy;

    // Toggle acceptance, completion tracking and clamp control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= 1'b0;
            busy  <= 1'b0;
            stat  <= 1'b0;
            clamp <= 1'b1;
        end else begin
            if (tog && !busy) begin
                en   <= !en;
                busy <= 1'b1;
                if (en) clamp <= 1'b1;
            end else if (busy && (pg == en)) begin
                busy <= 1'b0;
                stat <= en;
            end
            if (rel && en) clamp <= 1'b0;
        end
    end
endmodule

// File: rtl/pgate_ctrl.sv
// Top: register-mapped gating controller for NPART power partitions.
// Assumes a synchronous active-low reset and a combinational read path.
module pgate_ctrl
    import pgate_pkg::*;
#(
    parameter int NPART  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SWAP_A = 3,
    parameter int SWAP_B = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NPART-1:0]  pwr_en,
    input  logic [NPART-1:0]  pwr_good,
    output logic [NPART-1:0]  iso_clamp
);
    logic [NPART-1:0] tog_sel;
    logic [NPART-1:0] rel_req;
    logic [NPART-1:0] stat_q;

    pgate_regdec #(
        .NPART(NPART), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SWAP_A(SWAP_A), .SWAP_B(SWAP_B)
    ) u_dec (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .tog_sel  (tog_sel),
        .rel_req  (rel_req)
    );

    for (genvar p = 0; p < NPART; p++) begin : g_part
        pgate_slice u_sl (
            .clk  (clk),
            .rst_n(rst_n),
            .tog  (tog_sel[p]),
            .rel  (rel_req[p]),
            .pg   (pwr_good[p]),
            .en   (pwr_en[p]),
            .stat (stat_q[p]),
            .clamp(iso_clamp[p])
        );
    end

    // Read mux: status at its offset, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_STATUS)) bus_rdata[NPART-1:0] = stat_q;
    end
endmodule

// File: rtl/pgate_chk.sv
// Checker: temporal properties of the gating controller, bound to the top.
module pgate_chk
    import pgate_pkg::*;
#(
    parameter int NPART  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NPART-1:0]  pwr_en,
    input logic [NPART-1:0]  pwr_good,
    input logic [NPART-1:0]  iso_clamp,
    input logic [NPART-1:0]  stat_q
);
    logic tog_wr;
    assign tog_wr = bus_we && (bus_addr == ADDR_W'(OFF_TOGGLE)) && bus_wdata[START_BIT];

    p_one_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> $countones(pwr_en ^ $past(pwr_en)) <= 1);

    p_flip_needs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tog_wr |=> pwr_en == $past(pwr_en));

    p_status_follows_good_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> ((stat_q ^ $past(stat_q)) & ($past(pwr_good) ^ stat_q)) == '0);

    p_off_is_clamped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> (~pwr_en & ~iso_clamp) == '0);

    p_clamp_rise_on_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> ((($past(pwr_en) & ~pwr_en) & ~iso_clamp) == '0));
endmodule

bind pgate_ctrl pgate_chk #(.NPART(NPART), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .pwr_en(pwr_en), .pwr_good(pwr_good),
    .iso_clamp(iso_clamp), .stat_q(stat_q)
);

// File: tb/sim_pgate_ctrl.sv
`timescale 1ns/1ps
module sim_pgate_ctrl;
    localparam int NP = 8;
    localparam int SA = 3;
    localparam int SB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pwr_en;
    logic [NP-1:0] pwr_good = '0;
    logic [NP-1:0] iso_clamp;

    int checks = 0;
    int errors = 0;
    logic [NP-1:0] exp_en = '0;
    logic [NP-1:0] exp_st = '0;
    logic [NP-1:0] exp_cl = '1;

    always #2.5 clk = ~clk;

    pgate_ctrl #(.NPART(NP), .SWAP_A(SA), .SWAP_B(SB)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_en(pwr_en),
        .pwr_good(pwr_good), .iso_clamp(iso_clamp)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #0.2; d = bus_rdata;
    endtask

    task automatic tick;
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 en", 32'(pwr_en), 32'(exp_en));
        chk("R1 clamp", 32'(iso_clamp), 32'(exp_cl));
        rd(8'h38, r); chk("R1 status", r, 0);

        // Power every partition on, with busy-ignore and delayed good.
        for (int i = 0; i < NP; i++) begin
            wr(8'h30, 32'h100 | i);
            exp_en[i] = 1'b1;
            chk("R2 toggle on", 32'(pwr_en), 32'(exp_en));
            rd(8'h38, r); chk("R4 status holds", r, 32'(exp_st));
            wr(8'h30, 32'h100 | i);
            chk("R5 busy ignore", 32'(pwr_en), 32'(exp_en));
            tick;
            rd(8'h38, r); chk("R4 still pending", r, 32'(exp_st));
            pwr_good[i] = 1'b1;
            tick;
            exp_st[i] = 1'b1;
            rd(8'h38, r); chk("R4 status set", r, 32'(exp_st));
        end

        // R3 no start flag, R10 out-of-range index
        wr(8'h30, 32'h000);
        chk("R3 no start", 32'(pwr_en), 32'(exp_en));
        wr(8'h30, 32'h109);
        chk("R10 index 9", 32'(pwr_en), 32'(exp_en));
        wr(8'h30, 32'h11F);
        chk("R10 index 31", 32'(pwr_en), 32'(exp_en));

        // R7 zero write does nothing
        wr(8'h34, 32'h0);
        chk("R7 zero write", 32'(iso_clamp), 32'(exp_cl));
        // R7/R8 release each bit in turn
        for (int b = 0; b < NP; b++) begin
            int p;
            p = (b == SA) ? SB : (b == SB) ? SA : b;
            wr(8'h34, 32'(1) << b);
            exp_cl[p] = 1'b0;
            chk((b == SA || b == SB) ? "R8 swapped release" : "R7 release",
                32'(iso_clamp), 32'(exp_cl));
        end

        // R9 power off partition 2 reasserts clamp
        wr(8'h30, 32'h102);
        exp_en[2] = 1'b0; exp_cl[2] = 1'b1;
        chk("R9 en off", 32'(pwr_en), 32'(exp_en));
        chk("R9 clamp back", 32'(iso_clamp), 32'(exp_cl));
        rd(8'h38, r); chk("R4 off pending", r, 32'(exp_st));
        pwr_good[2] = 1'b0;
        tick;
        exp_st[2] = 1'b0;
        rd(8'h38, r); chk("R4 off done", r, 32'(exp_st));
        // R7 release of an unpowered partition ignored
        wr(8'h34, 32'h4);
        chk("R7 unpowered", 32'(iso_clamp), 32'(exp_cl));
        // R8 power off 4, release bit 3 leaves clamp 4 set
        wr(8'h30, 32'h104);
        exp_en[4] = 1'b0; exp_cl[4] = 1'b1;
        pwr_good[4] = 1'b0;
        tick;
        exp_st[4] = 1'b0;
        wr(8'h34, 32'h8);
        chk("R8 bit3 to off part4", 32'(iso_clamp), 32'(exp_cl));

        // R6 other offsets read zero, status offset reads status
        rd(8'h30, r); chk("R6 offset 30", r, 0);
        rd(8'h34, r); chk("R6 offset 34", r, 0);
        rd(8'h3C, r); chk("R6 offset 3C", r, 0);
        rd(8'h38, r); chk("R6 status", r, 32'(exp_st));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule